// File: doc/BRIEF.md
# Programmable Butterfly Bit-Permute Unit

This unit sends a data word through a stack of butterfly rows whose strides double from 1 up to half the word width. A fixed-swap butterfly can only exchange bit pairs. Here, every enabled row computes each output bit as a 2-input lookup of the bit itself and its partner at distance `s`. The table comes from an 8-bit operand. Its low nibble serves the lower member of each pair and its high nibble serves the upper member. With the right tables, one configuration performs a plain generalised bit-reverse, another performs an OR-combine, and others build regular constant masks.

When the caller marks the source as "zero register", the unit starts from an alternating `0101...` seed instead of the source value. This seed can be complemented, so the unit also produces constants. A half-width mode works on the low 32 bits only. A per-row mode applies every row and takes a separate table byte for each row from the control operand.

Requests arrive on a valid/ready input and leave on a valid/ready output through one register stage. A request is accepted when `in_valid` and `in_ready` are both high. `in_ready` is high whenever the output register is empty or is being drained in the same cycle. While `out_valid` is high and `out_ready` is low, the result holds steady and no new request is taken.

Top module: `grl_unit`

## Requirements
- R1: `in_ready` is high when `out_valid` is low or `out_ready` is high. An accepted request appears on `out_data`, with `out_valid` high, after the next rising clock edge. A new request may be accepted in the same cycle that the previous result is drained.
- R2: While `out_valid` is high and `out_ready` is low, `in_ready` is low, and `out_valid` and `out_data` keep their values.
- R3: The starting value is 0x5555_5555_5555_5555 when `in_src_zero` is 1. Otherwise it is `in_src`.
- R4: When `in_inv` is 1, the starting value is complemented, so a zero source starts from 0xAAAA_AAAA_AAAA_AAAA.
- R5: In full-width normal mode, the rows are applied in order of stride 1, 2, 4, 8, 16, 32. Row k (stride 2^k) is applied only when `in_ctl[k]` is 1. Bits of `in_ctl` above bit 5 have no effect.
- R6: Within a row of stride s, output bit j = T[idx]. The index idx = {x[j & ~s], x[j | s]}: bit 1 of idx is the pair's lower-position bit and bit 0 is its upper-position bit. T is imm[3:0] when (j & s) == 0 and imm[7:4] otherwise.
- R7: Table byte 0xCA gives a generalised bit-reverse: each enabled row swaps each bit with its partner. Table byte 0xEE gives an OR-combine: each enabled row ORs each bit with its partner.
- R8: With `in_w32` = 1, only rows of stride 1 to 16 can apply, selected by `in_ctl[4:0]`. The rows act on bits 0..31, `in_ctl[5]` has no effect, and `out_data[63:32]` is zero.
- R9: With `in_per_row` = 1, every row is applied (five rows in half-width mode), and row k uses `in_ctl[8k+7:8k]` as its table. `in_imm` has no effect.
- R10: With a zero source, no invert and table 0x6C, the results are 0x1111_1111_1111_1111 for amount 0b10, 0x0101_0101_0101_0101 for 0b110 and 0x0001_0001_0001_0001 for 0b1110. With invert and table 0xC6, amount 0b10 gives 0x8888_8888_8888_8888.
- R11: After reset, `out_valid` is 0 and `in_ready` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Request present |
| in_ready | output | 1 | Request can be taken this cycle |
| in_src | input | 64 | Source data word |
| in_src_zero | input | 1 | Use the alternating seed instead of `in_src` |
| in_ctl | input | 48 | Row-enable amount (low bits), or per-row table bytes |
| in_imm | input | 8 | Table pair used in normal mode |
| in_inv | input | 1 | Complement the starting value |
| in_w32 | input | 1 | Half-width mode |
| in_per_row | input | 1 | Apply all rows with per-row tables |
| out_valid | output | 1 | Result present |
| out_ready | input | 1 | Consumer takes the result this cycle |
| out_data | output | 64 | Result word |

## Verification
The case that matters is a result being drained while a new request is accepted in the same cycle. The bench reaches it by holding `out_ready` low after one accepted word, so a second request waits with `in_valid` high. The bench then raises `out_ready`, and at the same edge the first word leaves and the second is captured. The second word must appear exactly one edge later, and the first must stay unchanged for every stalled cycle before that. Back-to-back transfers with `out_ready` held high exercise the same overlap on every cycle.

// File: rtl/grl_pkg.sv
package grl_pkg;

  // Pick one entry of a 4-entry lookup table. Index bit 1 is the bit at the
  // lower position of the pair, index bit 0 the bit at the upper position.
  function automatic logic lut2_pick(input logic [3:0] tbl,
                                     input logic lo_bit,
                                     input logic hi_bit);
    return tbl[{lo_bit, hi_bit}];
  endfunction

endpackage

// File: rtl/grl_seed.sv
module grl_seed #(
  parameter int XLEN = 64
) (
  input  logic [XLEN-1:0] src,
  input  logic            src_zero,
  input  logic            inv,
  output logic [XLEN-1:0] seed
);
  localparam logic [XLEN-1:0] ALT = {(XLEN/2){2'b01}};

  logic [XLEN-1:0] base;

  always_comb begin
    base = src_zero ? ALT : src;
    seed = inv ? ~base : base;
  end
endmodule

// File: rtl/grl_ctl.sv
module grl_ctl #(
  parameter int XLEN = 64,
  localparam int ROWS = $clog2(XLEN),
  localparam int CTLW = 8 * ROWS
) (
  input  logic [CTLW-1:0]   ctl,
  input  logic [7:0]        imm,
  input  logic              w32,
  input  logic              per_row,
  output logic [ROWS-1:0]   row_en,
  output logic [CTLW-1:0]   row_lut
);
  for (genvar k = 0; k < ROWS; k++) begin : g_row
    if (k == ROWS - 1) begin : g_top
      // widest stride only exists in full-width mode
      assign row_en[k] = !w32 && (per_row || ctl[k]);
    end else begin : g_low
      assign row_en[k] = per_row || ctl[k];
    end
    assign row_lut[8*k +: 8] = per_row ? ctl[8*k +: 8] : imm;
  end
endmodule

// File: rtl/grl_row.sv
module grl_row #(
  parameter int XLEN   = 64,
  parameter int STRIDE = 1
) (
  input  logic [XLEN-1:0] x,
  input  logic            en,
  input  logic [7:0]      lut,
  output logic [XLEN-1:0] y
);
  import grl_pkg::*;

  for (genvar j = 0; j < XLEN; j++) begin : g_bit
    localparam int LO    = j & ~STRIDE;
    localparam int HI    = j | STRIDE;
    localparam bit UPPER = (j & STRIDE) != 0;
    logic [3:0] tbl;
    assign tbl  = UPPER ? lut[7:4] : lut[3:0];
    assign y[j] = en ? lut2_pick(tbl, x[LO], x[HI]) : x[j];
  end
endmodule

// File: rtl/grl_unit.sv
module grl_unit #(
  parameter int XLEN = 64,
  localparam int ROWS = $clog2(XLEN),
  localparam int CTLW = 8 * ROWS,
  localparam int HALF = XLEN / 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            in_valid,
  output logic            in_ready,
  input  logic [XLEN-1:0] in_src,
  input  logic            in_src_zero,
  input  logic [CTLW-1:0] in_ctl,
  input  logic [7:0]      in_imm,
  input  logic            in_inv,
  input  logic            in_w32,
  input  logic            in_per_row,
  output logic            out_valid,
  input  logic            out_ready,
  output logic [XLEN-1:0] out_data
);
  logic [XLEN-1:0] stage [ROWS+1];
  logic [ROWS-1:0] row_en;
  logic [CTLW-1:0] row_lut;
  logic [XLEN-1:0] result;
  logic            accept;

  grl_seed #(.XLEN(XLEN)) u_seed (
    .src(in_src), .src_zero(in_src_zero), .inv(in_inv), .seed(stage[0])
  );

  grl_ctl #(.XLEN(XLEN)) u_ctl (
    .ctl(in_ctl), .imm(in_imm), .w32(in_w32), .per_row(in_per_row),
    .row_en(row_en), .row_lut(row_lut)
  );

  for (genvar k = 0; k < ROWS; k++) begin : g_rows
    grl_row #(.XLEN(XLEN), .STRIDE(1 << k)) u_row (
      .x(stage[k]), .en(row_en[k]), .lut(row_lut[8*k +: 8]), .y(stage[k+1])
    );
  end

  always_comb begin
    result = in_w32 ? {{HALF{1'b0}}, stage[ROWS][HALF-1:0]} : stage[ROWS];
  end

  assign in_ready = !out_valid || out_ready;
  assign accept   = in_valid && in_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_data  <= '0;
    end else if (accept) begin
      out_valid <= 1'b1;
      out_data  <= result;
    end else if (out_ready) begin
      out_valid <= 1'b0;
    end
  end
endmodule

// File: rtl/grl_chk.sv
module grl_chk #(
  parameter int XLEN = 64,
  localparam int ROWS = $clog2(XLEN),
  localparam int CTLW = 8 * ROWS,
  localparam int HALF = XLEN / 2
) (
  input logic            clk,
  input logic            rst_n,
  input logic            in_valid,
  input logic            in_ready,
  input logic            in_src_zero,
  input logic [CTLW-1:0] in_ctl,
  input logic            in_inv,
  input logic            in_w32,
  input logic            in_per_row,
  input logic            out_valid,
  input logic            out_ready,
  input logic [XLEN-1:0] out_data
);
  localparam logic [XLEN-1:0] ALT = {(XLEN/2){2'b01}};

  logic take_plain_seed;
  assign take_plain_seed = in_valid && in_ready && in_src_zero && !in_per_row &&
                           !in_w32 && (in_ctl[ROWS-1:0] == '0);

  AST_ACCEPT_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready |=> out_valid); // R1

  AST_STALL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_data)); // R2

  AST_STALL_BLOCK: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |-> !in_ready); // R2

  AST_SEED_PLAIN: assert property (@(posedge clk) disable iff (!rst_n)
    take_plain_seed && !in_inv |=> out_data == ALT); // R3

  AST_SEED_INV: assert property (@(posedge clk) disable iff (!rst_n)
    take_plain_seed && in_inv |=> out_data == ~ALT); // R4

  AST_HALF_UPPER: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready && in_w32 |=> out_data[XLEN-1:HALF] == '0); // R8
endmodule

bind grl_unit grl_chk #(.XLEN(XLEN)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
  .in_src_zero(in_src_zero), .in_ctl(in_ctl), .in_inv(in_inv),
  .in_w32(in_w32), .in_per_row(in_per_row), .out_valid(out_valid),
  .out_ready(out_ready), .out_data(out_data)
);

// File: tb/sim_grl_unit.sv
module sim_grl_unit;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [63:0] in_src = '0;
  logic        in_src_zero = 1'b0;
  logic [47:0] in_ctl = '0;
  logic [7:0]  in_imm = '0;
  logic        in_inv = 1'b0;
  logic        in_w32 = 1'b0;
  logic        in_per_row = 1'b0;
  logic        out_valid;
  logic        out_ready = 1'b1;
  logic [63:0] out_data;

  int n_run = 0;
  int n_fail = 0;
  bit done = 0;
  logic [63:0] lcg = 64'h1234_5678_9abc_def1;

  always #10 clk = ~clk;

  grl_unit u0 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_src(in_src), .in_src_zero(in_src_zero), .in_ctl(in_ctl),
    .in_imm(in_imm), .in_inv(in_inv), .in_w32(in_w32),
    .in_per_row(in_per_row), .out_valid(out_valid), .out_ready(out_ready),
    .out_data(out_data)
  );

  function automatic logic [63:0] rnd();
    lcg = lcg * 64'd6364136223846793005 + 64'd1442695040888963407;
    return lcg ^ (lcg >> 29);
  endfunction

  // bit-level model built from the requirements (R3..R9)
  function automatic logic [63:0] model(input logic [63:0] src, input logic zero,
      input logic [47:0] ctl, input logic [7:0] imm, input logic inv,
      input logic w32, input logic pr);
    logic [63:0] x, y;
    logic [7:0]  t;
    logic [1:0]  idx;
    x = zero ? 64'h5555_5555_5555_5555 : src;
    if (inv) x = ~x;
    for (int r = 0; r < (w32 ? 5 : 6); r++) begin
      int s;
      s = 1 << r;
      t = pr ? ctl[8*r +: 8] : imm;
      if (pr || ctl[r]) begin
        for (int j = 0; j < 64; j++) begin
          idx = {x[j & ~s], x[j | s]};
          y[j] = ((j & s) != 0) ? t[4 + idx] : t[idx];
        end
        x = y;
      end
    end
    if (w32) x[63:32] = '0;
    return x;
  endfunction

  function automatic logic [63:0] stride_mask(input int s);
    logic [63:0] m;
    for (int j = 0; j < 64; j++) m[j] = ((j & s) == 0);
    return m;
  endfunction

  function automatic logic [63:0] grev_ref(input logic [63:0] v, input logic [5:0] a, input bit orc);
    logic [63:0] x, sw, m;
    x = v;
    for (int r = 0; r < 6; r++) begin
      if (a[r]) begin
        m = stride_mask(1 << r);
        sw = ((x & m) << (1 << r)) | ((x & ~m) >> (1 << r));
        x = orc ? (x | sw) : sw;
      end
    end
    return x;
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic drive(input logic [63:0] src, input logic zero, input logic [47:0] ctl,
      input logic [7:0] imm, input logic inv, input logic w32, input logic pr);
    in_src = src; in_src_zero = zero; in_ctl = ctl; in_imm = imm;
    in_inv = inv; in_w32 = w32; in_per_row = pr; in_valid = 1'b1;
  endtask

  // one transfer with out_ready high; result sampled at the next falling edge
  task automatic xfer(input logic [63:0] src, input logic zero, input logic [47:0] ctl,
      input logic [7:0] imm, input logic inv, input logic w32, input logic pr,
      output logic [63:0] got);
    @(negedge clk);
    out_ready = 1'b1;
    drive(src, zero, ctl, imm, inv, w32, pr);
    @(posedge clk);
    @(negedge clk);
    in_valid = 1'b0;
    got = out_valid ? out_data : 64'hxxxx_xxxx_xxxx_xxxx;
  endtask

  task automatic run(input string tag, input logic [63:0] src, input logic zero,
      input logic [47:0] ctl, input logic [7:0] imm, input logic inv,
      input logic w32, input logic pr);
    logic [63:0] got, exp;
    xfer(src, zero, ctl, imm, inv, w32, pr, got);
    exp = model(src, zero, ctl, imm, inv, w32, pr);
    chk(got === exp, tag, got, exp);
  endtask

  initial begin
    #(20 * 150000);
    n_fail++;
    $display("FAIL watchdog expired actual=%h expected=%h", 64'd0, 64'd1);
    if (!done) begin
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    logic [63:0] got, a, b, v;
    logic [7:0]  imms [8];
    imms = '{8'hCA, 8'hEE, 8'h6C, 8'hC6, 8'h00, 8'hFF, 8'h96, 8'h35};

    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(out_valid === 1'b0, "R11 out_valid after reset", {63'd0, out_valid}, 64'd0);
    chk(in_ready === 1'b1, "R11 in_ready after reset", {63'd0, in_ready}, 64'd1);
    rst_n = 1'b1;

    // R3 / R4 seeds with no rows
    xfer(64'h0, 1, 48'h0, 8'h00, 0, 0, 0, got);
    chk(got === 64'h5555_5555_5555_5555, "R3 zero seed", got, 64'h5555_5555_5555_5555);
    xfer(64'hDEAD_BEEF_0123_4567, 0, 48'h0, 8'h00, 0, 0, 0, got);
    chk(got === 64'hDEAD_BEEF_0123_4567, "R3 plain source", got, 64'hDEAD_BEEF_0123_4567);
    xfer(64'h0, 1, 48'h0, 8'h00, 1, 0, 0, got);
    chk(got === 64'hAAAA_AAAA_AAAA_AAAA, "R4 inverted zero seed", got, 64'hAAAA_AAAA_AAAA_AAAA);
    xfer(64'hDEAD_BEEF_0123_4567, 0, 48'h0, 8'h00, 1, 0, 0, got);
    chk(got === ~64'hDEAD_BEEF_0123_4567, "R4 inverted source", got, ~64'hDEAD_BEEF_0123_4567);

    // R10 constant patterns
    xfer(64'h0, 1, 48'h2, 8'h6C, 0, 0, 0, got);
    chk(got === 64'h1111_1111_1111_1111, "R10 amt 0b10", got, 64'h1111_1111_1111_1111);
    xfer(64'h0, 1, 48'h6, 8'h6C, 0, 0, 0, got);
    chk(got === 64'h0101_0101_0101_0101, "R10 amt 0b110", got, 64'h0101_0101_0101_0101);
    xfer(64'h0, 1, 48'hE, 8'h6C, 0, 0, 0, got);
    chk(got === 64'h0001_0001_0001_0001, "R10 amt 0b1110", got, 64'h0001_0001_0001_0001);
    xfer(64'h0, 1, 48'h2, 8'hC6, 1, 0, 0, got);
    chk(got === 64'h8888_8888_8888_8888, "R10 inverted amt 0b10", got, 64'h8888_8888_8888_8888);

    // R7 full amount sweep against mask-and-shift reference
    for (int amt = 0; amt < 64; amt++) begin
      v = rnd();
      xfer(v, 0, 48'(amt), 8'hCA, 0, 0, 0, got);
      chk(got === grev_ref(v, 6'(amt), 0), "R7 grev table", got, grev_ref(v, 6'(amt), 0));
      xfer(v & rnd() & rnd(), 0, 48'(amt), 8'hEE, 0, 0, 0, got);
      a = grev_ref(in_src, 6'(amt), 1);
      chk(got === a, "R7 gorc table", got, a);
    end

    // R6 every table on every single row
    for (int r = 0; r < 6; r++)
      for (int t = 0; t < 256; t++)
        run("R6 single row table sweep", rnd(), 0, 48'(1 << r), 8'(t), 0, 0, 0);

    // R5 multi-row amounts, upper control bits must not matter
    for (int amt = 0; amt < 64; amt++)
      for (int i = 0; i < 8; i++) begin
        v = rnd();
        xfer(v, 0, {rnd()} [47:0] & ~48'h3F | 48'(amt), imms[i], 0, 0, 0, got);
        a = model(v, 0, 48'(amt), imms[i], 0, 0, 0);
        chk(got === a, "R5 row order and amount mask", got, a);
      end

    // R8 half-width sweep, ctl[5] set to show it is ignored
    for (int amt = 0; amt < 32; amt++)
      for (int i = 0; i < 8; i++) begin
        v = rnd();
        xfer(v, amt[0], 48'(amt) | 48'h20, imms[i], amt[1], 1, 0, got);
        a = model(v, amt[0], 48'(amt), imms[i], amt[1], 1, 0);
        chk(got === a, "R8 half-width", got, a);
      end

    // R9 per-row tables, immediate ignored
    for (int i = 0; i < 200; i++) begin
      logic [47:0] c;
      c = rnd()[47:0];
      v = rnd();
      xfer(v, i[0], c, 8'h00, i[1], i[2], 1, a);
      xfer(v, i[0], c, 8'hFF, i[1], i[2], 1, b);
      got = model(v, i[0], c, 8'h5A, i[1], i[2], 1);
      chk(a === got, "R9 per-row tables", a, got);
      chk(b === a, "R9 immediate ignored", b, a);
    end

    // R1 back-to-back with out_ready high
    @(negedge clk);
    out_ready = 1'b1;
    drive(64'h0F0F_1234_5678_9ABC, 0, 48'h3, 8'hCA, 0, 0, 0);
    @(posedge clk);
    @(negedge clk);
    a = model(64'h0F0F_1234_5678_9ABC, 0, 48'h3, 8'hCA, 0, 0, 0);
    chk(out_valid && out_data === a, "R1 first of pair", out_data, a);
    chk(in_ready === 1'b1, "R1 ready while draining", {63'd0, in_ready}, 64'd1);
    drive(64'h0, 1, 48'h6, 8'h6C, 0, 0, 0);
    @(posedge clk);
    @(negedge clk);
    in_valid = 1'b0;
    chk(out_valid && out_data === 64'h0101_0101_0101_0101, "R1 second of pair",
        out_data, 64'h0101_0101_0101_0101);

    // R2 stall, then drain and accept in the same cycle
    @(negedge clk);
    out_ready = 1'b0;
    drive(64'hCAFE_F00D_0000_FFFF, 0, 48'h10, 8'hCA, 0, 0, 0);
    @(posedge clk);
    @(negedge clk);
    a = model(64'hCAFE_F00D_0000_FFFF, 0, 48'h10, 8'hCA, 0, 0, 0);
    drive(64'h0, 1, 48'h2, 8'hC6, 1, 0, 0);
    chk(in_ready === 1'b0, "R2 not ready while full", {63'd0, in_ready}, 64'd0);
    for (int k = 0; k < 3; k++) begin
      @(posedge clk);
      @(negedge clk);
      chk(out_valid && out_data === a, "R2 held result", out_data, a);
      chk(in_ready === 1'b0, "R2 still blocked", {63'd0, in_ready}, 64'd0);
    end
    out_ready = 1'b1;
    @(posedge clk);
    @(negedge clk);
    in_valid = 1'b0;
    chk(out_valid && out_data === 64'h8888_8888_8888_8888, "R1 R2 accepted on drain",
        out_data, 64'h8888_8888_8888_8888);
    @(negedge clk);
    chk(out_valid === 1'b0, "R1 empty after drain", {63'd0, out_valid}, 64'd0);

    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule